// File: doc/BRIEF.md
# SDRAM Command Sequencing Controller

This controller connects a simple one-request-at-a-time host port to a single-data-rate synchronous DRAM with four internal banks and a 16-bit data bus. After reset it brings the memory up on its own: it waits out a power-up interval with the clock enable raised, closes every bank, runs a number of refresh cycles and then programs the mode register. Until that register is written, no row or column command reaches the memory.

A host request carries a flat word address, a direction flag and, for writes, one data word. The address is split with the bank in the top bits, the row in the middle and the column in the low bits. Each access opens its row with an activate, waits the row-to-column delay, and issues one read or write with the auto-precharge bit set, so the row closes by itself. Only one row is open at any time. The burst length is one. Read data comes back on the host side with a one-cycle valid strobe a fixed number of cycles after the read. A pacing counter asks for an auto refresh at regular intervals so that all 8192 rows are covered once per refresh period. At the idle point a refresh that is due goes ahead of a waiting host request.

Top module: `sdram_seq_ctrl`

## Requirements
- R1: While reset is low, the clock enable is low, the command pins carry NOP (CS#,RAS#,CAS#,WE# = 0111), the data driver is off and the read strobe is low. Whenever the clock enable is low, the command is NOP.
- R2: After reset the first command other than NOP comes at least T_POWERUP cycles after the clock enable rises, and it is a PRECHARGE (0010) with address bit 10 high, which closes all banks.
- R3: Between that precharge and the mode load, exactly INIT_REFS AUTO REFRESH commands (0001) are issued.
- R4: The mode load (0000) drives bank bits 0 and an address word with CAS latency in bits 6:4, burst length one (bits 2:0 = 000), sequential order (bit 3 = 0) and all other bits 0, which is 0x020 for latency 2. No ACTIVE, READ or WRITE appears before it.
- R5: A host address is split as bank = address[24:23], row = address[22:10], column = address[9:0]; ACTIVE (0011) drives the bank and row, and the column command drives the same bank with the column on address bits 9:0.
- R6: Every READ (0101) and WRITE (0100) follows an ACTIVE to the same bank with no other command between them, has address bit 10 high (auto precharge) and address bits 12:11 low.
- R7: A column command comes at least T_RCD cycles after its ACTIVE.
- R8: After a WRITE the next command comes no earlier than T_WR+T_RP cycles later; after a READ no earlier than T_CL+T_RP cycles later.
- R9: After PRECHARGE the next command waits at least T_RP cycles, after AUTO REFRESH at least T_RFC cycles, after the mode load at least T_MRD cycles.
- R10: Once the mode is loaded, AUTO REFRESH commands follow each other at intervals of REF_PERIOD_CYC/8192 cycles, each within 10 cycles of that interval.
- R11: A refresh that is due is issued ahead of a waiting host request, so the interval of R10 holds while the host offers requests without pause.
- R12: A WRITE drives the request's data with the driver enabled and both byte masks low; in every other cycle the driver is off.
- R13: For each READ, the read strobe is high for one cycle exactly T_CL+1 cycles after the READ appears on the pins, with the word the memory returned; it is low at all other times.
- R14: The host ready output is high only when the controller can start an access at once; a request seen with ready high is followed by its ACTIVE in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and memory clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_valid | input | 1 | Host offers a request |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 25 | Flat word address {bank,row,column} |
| host_wdata | input | 16 | Write data |
| host_ready | output | 1 | Request is taken in this cycle if valid |
| host_rdata | output | 16 | Returned read word |
| host_rvalid | output | 1 | One-cycle strobe for host_rdata |
| sd_cke | output | 1 | Memory clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 13 | Multiplexed row/column/mode address |
| sd_dqm | output | 2 | Byte masks, high masks |
| sd_dq_out | output | 16 | Data toward the memory |
| sd_dq_oe | output | 1 | Data driver enable |
| sd_dq_in | input | 16 | Data from the memory |

## Verification
A wrong sequencer state shows on the command pins within one cycle: a command too close to its predecessor, a column command without its activate, or a missing auto-precharge bit, all of which a per-cycle protocol model catches at the cycle they appear. A wrong address split or data path shows as a read returning a word other than the one written to that location, visible at the strobe T_CL+1 cycles after the read. A fault in refresh pacing shows only after an interval of REF_PERIOD_CYC/8192 cycles, as a refresh gap outside its window, so the bench runs long stretches of continuous traffic across many intervals.

// File: rtl/sdr_pkg.sv
// Shared types for the SDRAM command sequencer.
// Assumes the command pins are ordered CS#, RAS#, CAS#, WE# from MSB to LSB.
package sdr_pkg;

    typedef enum logic [3:0] {
        CMD_LOAD  = 4'b0000,
        CMD_REF   = 4'b0001,
        CMD_PRE   = 4'b0010,
        CMD_ACT   = 4'b0011,
        CMD_WRITE = 4'b0100,
        CMD_READ  = 4'b0101,
        CMD_NOP   = 4'b0111
    } sdr_cmd_e;

    typedef enum logic [2:0] {
        ST_POWERUP,
        ST_PRE_ALL,
        ST_INIT_REF,
        ST_MODE,
        ST_IDLE,
        ST_COL
    } sdr_state_e;

    // Address bit that requests auto precharge on a column command.
    localparam int AP_POS = 10;

endpackage

// File: rtl/sdr_addr_split.sv
// Splits a flat host word address into bank, row and column fields.
// Assumes the layout {bank, row, column} from MSB to LSB.
module sdr_addr_split #(
    parameter int BA_W  = 2,
    parameter int ROW_W = 13,
    parameter int COL_W = 10,
    localparam int ADDR_W = BA_W + ROW_W + COL_W
) (
    input  logic [ADDR_W-1:0] flat_addr,
    output logic [BA_W-1:0]   bank,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col
);

    // Field extraction, pure wiring.
    always_comb begin
        bank = flat_addr[ADDR_W-1 -: BA_W];
        row  = flat_addr[COL_W +: ROW_W];
        col  = flat_addr[COL_W-1:0];
    end

endmodule

// File: rtl/sdr_refresh_timer.sv
// Paces auto refresh: raises a pending flag every T_REFI cycles once enabled.
// Assumes the sequencer acknowledges a pending refresh well within T_REFI.
module sdr_refresh_timer #(
    parameter int T_REFI = 1039,
    localparam int REF_W = $clog2(T_REFI + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic ack,
    output logic pending
);

    logic [REF_W-1:0] tick_cnt;
    logic             tick;

    assign tick = (tick_cnt == REF_W'(T_REFI - 1));

    // Interval counter and pending flag; a new tick wins over an ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            pending  <= 1'b0;
        end else if (!enable) begin
            tick_cnt <= '0;
            pending  <= 1'b0;
        end else begin
            tick_cnt <= tick ? '0 : tick_cnt + 1'b1;
            if (tick)
                pending <= 1'b1;
            else if (ack)
                pending <= 1'b0;
        end
    end

endmodule

// File: rtl/sdr_rd_capture.sv
// Captures read data T_CL cycles after a READ leaves the command register,
// i.e. at the edge where the memory presents it, and strobes it to the host.
// Assumes burst length one and T_CL >= 1.
module sdr_rd_capture #(
    parameter int T_CL = 2,
    parameter int DQ_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            read_issued,
    input  logic [DQ_W-1:0] dq_in,
    output logic            rvalid,
    output logic [DQ_W-1:0] rdata
);

    logic [T_CL-1:0] lat_pipe;

    generate
        if (T_CL == 1) begin : g_one
            // Single-stage latency tracker.
            always_ff @(posedge clk) begin
                if (!rst_n) lat_pipe <= '0;
                else        lat_pipe <= read_issued;
            end
        end else begin : g_multi
            // Latency shift register, one stage per CAS cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) lat_pipe <= '0;
                else        lat_pipe <= {lat_pipe[T_CL-2:0], read_issued};
            end
        end
    endgenerate

    // Data capture and host strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= lat_pipe[T_CL-1];
            if (lat_pipe[T_CL-1])
                rdata <= dq_in;
        end
    end

endmodule

// File: rtl/sdr_cmd_fsm.sv
// Command sequencer: power-up, mode load, refresh and single-row accesses
// closed by auto precharge. All memory-side outputs are registered.
// Assumes burst length one; one access is in flight at a time.
module sdr_cmd_fsm import sdr_pkg::*; #(
    parameter int BA_W      = 2,
    parameter int ROW_W     = 13,
    parameter int COL_W     = 10,
    parameter int DQ_W      = 16,
    parameter int T_POWERUP = 26600,
    parameter int T_RCD     = 2,
    parameter int T_RP      = 2,
    parameter int T_RFC     = 7,
    parameter int T_CL      = 2,
    parameter int T_MRD     = 2,
    parameter int T_WR      = 2,
    parameter int INIT_REFS = 2,
    localparam int DQM_W  = DQ_W / 8,
    localparam int WAIT_W = $clog2(T_POWERUP + T_RFC + T_RCD + T_RP + T_CL + T_MRD + T_WR + 1),
    localparam int RL_W   = $clog2(INIT_REFS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_valid,
    input  logic             host_write,
    input  logic [BA_W-1:0]  req_ba,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic [DQ_W-1:0]  host_wdata,
    output logic             host_ready,
    input  logic             ref_pending,
    output logic             ref_ack,
    output logic             init_done,
    output sdr_cmd_e         cmd_q,
    output logic             cke_q,
    output logic [BA_W-1:0]  ba_q,
    output logic [ROW_W-1:0] addr_q,
    output logic [DQ_W-1:0]  dq_out_q,
    output logic             dq_oe_q,
    output logic [DQM_W-1:0] dqm_q
);

    localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(T_CL << 4);
    localparam int WR_GAP = T_WR + T_RP;
    localparam int RD_GAP = T_CL + T_RP;

    sdr_state_e        state;
    logic [WAIT_W-1:0] wait_cnt;
    logic [RL_W-1:0]   refs_left;
    logic              lat_write;
    logic [BA_W-1:0]   lat_ba;
    logic [COL_W-1:0]  lat_col;
    logic [DQ_W-1:0]   lat_wdata;
    logic              at_idle;

    assign at_idle    = (state == ST_IDLE) && (wait_cnt == '0);
    assign ref_ack    = at_idle && ref_pending;
    assign host_ready = at_idle && !ref_pending;

    // Sequencer: one command per step, then NOPs while the wait counter runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_POWERUP;
            wait_cnt  <= '0;
            refs_left <= '0;
            cmd_q     <= CMD_NOP;
            cke_q     <= 1'b0;
            ba_q      <= '0;
            addr_q    <= '0;
            dq_out_q  <= '0;
            dq_oe_q   <= 1'b0;
            dqm_q     <= '1;
            init_done <= 1'b0;
            lat_write <= 1'b0;
            lat_ba    <= '0;
            lat_col   <= '0;
            lat_wdata <= '0;
        end else begin
            cmd_q   <= CMD_NOP;
            dq_oe_q <= 1'b0;
            if (wait_cnt != '0) begin
                wait_cnt <= wait_cnt - 1'b1;
            end else begin
                case (state)
                    ST_POWERUP: begin
                        cke_q    <= 1'b1;
                        wait_cnt <= WAIT_W'(T_POWERUP);
                        state    <= ST_PRE_ALL;
                    end
                    ST_PRE_ALL: begin
                        cmd_q          <= CMD_PRE;
                        addr_q         <= '0;
                        addr_q[AP_POS] <= 1'b1;
                        refs_left      <= RL_W'(INIT_REFS);
                        wait_cnt       <= WAIT_W'(T_RP - 1);
                        state          <= ST_INIT_REF;
                    end
                    ST_INIT_REF: begin
                        cmd_q     <= CMD_REF;
                        refs_left <= refs_left - 1'b1;
                        wait_cnt  <= WAIT_W'(T_RFC - 1);
                        if (refs_left == RL_W'(1))
                            state <= ST_MODE;
                    end
                    ST_MODE: begin
                        cmd_q     <= CMD_LOAD;
                        ba_q      <= '0;
                        addr_q    <= MODE_WORD;
                        dqm_q     <= '0;
                        init_done <= 1'b1;
                        wait_cnt  <= WAIT_W'(T_MRD - 1);
                        state     <= ST_IDLE;
                    end
                    ST_IDLE: begin
                        if (ref_pending) begin
                            cmd_q    <= CMD_REF;
                            wait_cnt <= WAIT_W'(T_RFC - 1);
                        end else if (host_valid) begin
                            cmd_q     <= CMD_ACT;
                            ba_q      <= req_ba;
                            addr_q    <= req_row;
                            lat_write <= host_write;
                            lat_ba    <= req_ba;
                            lat_col   <= req_col;
                            lat_wdata <= host_wdata;
                            wait_cnt  <= WAIT_W'(T_RCD - 1);
                            state     <= ST_COL;
                        end
                    end
                    ST_COL: begin
                        cmd_q                <= lat_write ? CMD_WRITE : CMD_READ;
                        ba_q                 <= lat_ba;
                        addr_q               <= '0;
                        addr_q[COL_W-1:0]    <= lat_col;
                        addr_q[AP_POS]       <= 1'b1;
                        dq_oe_q              <= lat_write;
                        dq_out_q             <= lat_write ? lat_wdata : dq_out_q;
                        wait_cnt             <= lat_write ? WAIT_W'(WR_GAP - 1)
                                                          : WAIT_W'(RD_GAP - 1);
                        state                <= ST_IDLE;
                    end
                    default: state <= ST_POWERUP;
                endcase
            end
        end
    end

endmodule

// File: rtl/sdram_seq_ctrl.sv
// Top of the SDRAM command sequencer: address split, sequencer, refresh
// pacing and read capture. Assumes a four-bank, 8192-row memory with
// 1024 columns, burst length one, and the memory on the same clock.
module sdram_seq_ctrl import sdr_pkg::*; #(
    parameter int BA_W           = 2,
    parameter int ROW_W          = 13,
    parameter int COL_W          = 10,
    parameter int DQ_W           = 16,
    parameter int T_POWERUP      = 26600,
    parameter int T_RCD          = 2,
    parameter int T_RP           = 2,
    parameter int T_RFC          = 7,
    parameter int T_CL           = 2,
    parameter int T_MRD          = 2,
    parameter int T_WR           = 2,
    parameter int INIT_REFS      = 2,
    parameter int REF_PERIOD_CYC = 8512000,
    localparam int ADDR_W = BA_W + ROW_W + COL_W,
    localparam int DQM_W  = DQ_W / 8,
    localparam int T_REFI = REF_PERIOD_CYC / (1 << ROW_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    input  logic              host_write,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DQ_W-1:0]   host_wdata,
    output logic              host_ready,
    output logic [DQ_W-1:0]   host_rdata,
    output logic              host_rvalid,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BA_W-1:0]   sd_ba,
    output logic [ROW_W-1:0]  sd_addr,
    output logic [DQM_W-1:0]  sd_dqm,
    output logic [DQ_W-1:0]   sd_dq_out,
    output logic              sd_dq_oe,
    input  logic [DQ_W-1:0]   sd_dq_in
);

    logic [BA_W-1:0]  req_ba;
    logic [ROW_W-1:0] req_row;
    logic [COL_W-1:0] req_col;
    logic             ref_pending;
    logic             ref_ack;
    logic             init_done;
    sdr_cmd_e         cmd_q;
    logic             rd_issue;

    sdr_addr_split #(.BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_split (
        .flat_addr (host_addr),
        .bank      (req_ba),
        .row       (req_row),
        .col       (req_col)
    );

    sdr_cmd_fsm #(
        .BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W),
        .T_POWERUP(T_POWERUP), .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC),
        .T_CL(T_CL), .T_MRD(T_MRD), .T_WR(T_WR), .INIT_REFS(INIT_REFS)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_valid  (host_valid),
        .host_write  (host_write),
        .req_ba      (req_ba),
        .req_row     (req_row),
        .req_col     (req_col),
        .host_wdata  (host_wdata),
        .host_ready  (host_ready),
        .ref_pending (ref_pending),
        .ref_ack     (ref_ack),
        .init_done   (init_done),
        .cmd_q       (cmd_q),
        .cke_q       (sd_cke),
        .ba_q        (sd_ba),
        .addr_q      (sd_addr),
        .dq_out_q    (sd_dq_out),
        .dq_oe_q     (sd_dq_oe),
        .dqm_q       (sd_dqm)
    );

    sdr_refresh_timer #(.T_REFI(T_REFI)) u_refresh (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (init_done),
        .ack     (ref_ack),
        .pending (ref_pending)
    );

    assign rd_issue = (cmd_q == CMD_READ);

    sdr_rd_capture #(.T_CL(T_CL), .DQ_W(DQ_W)) u_rdcap (
        .clk         (clk),
        .rst_n       (rst_n),
        .read_issued (rd_issue),
        .dq_in       (sd_dq_in),
        .rvalid      (host_rvalid),
        .rdata       (host_rdata)
    );

    // Command pins in CS#, RAS#, CAS#, WE# order.
    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

endmodule

// File: rtl/sdr_seq_chk.sv
// Protocol checker for the SDRAM command sequencer, observed at the pins.
// Tracks the last command, the cycles since it, and the open bank.
module sdr_seq_chk import sdr_pkg::*; #(
    parameter int BA_W  = 2,
    parameter int T_RCD = 2,
    parameter int T_RP  = 2,
    parameter int T_RFC = 7,
    parameter int T_MRD = 2,
    parameter int T_WR  = 2,
    parameter int T_CL  = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic [3:0]      cmd,
    input logic            cke,
    input logic [BA_W-1:0] ba,
    input logic            ap_bit,
    input logic            dq_oe,
    input logic            rvalid,
    input logic            host_valid,
    input logic            host_ready
);

    localparam int GAP_W = 8;
    localparam logic [GAP_W-1:0] GAP_MAX = '1;

    logic [GAP_W-1:0] gap;
    logic [GAP_W-1:0] need;
    logic [3:0]       last_cmd;
    logic [BA_W-1:0]  act_ba;
    logic             row_open;
    logic             mode_seen;
    logic             is_col;
    logic             is_op;

    assign is_col = (cmd == CMD_READ) || (cmd == CMD_WRITE);
    assign is_op  = is_col || (cmd == CMD_ACT);

    // History of the command stream seen on the pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap       <= GAP_MAX;
            last_cmd  <= CMD_NOP;
            act_ba    <= '0;
            row_open  <= 1'b0;
            mode_seen <= 1'b0;
        end else begin
            if (cmd != CMD_NOP) begin
                gap      <= GAP_W'(1);
                last_cmd <= cmd;
            end else if (gap != GAP_MAX) begin
                gap <= gap + 1'b1;
            end
            if (cmd == CMD_ACT) begin
                act_ba   <= ba;
                row_open <= 1'b1;
            end else if (is_col) begin
                row_open <= 1'b0;
            end
            if (cmd == CMD_LOAD)
                mode_seen <= 1'b1;
        end
    end

    // Minimum spacing owed to the previous command.
    always_comb begin
        case (last_cmd)
            CMD_PRE:   need = GAP_W'(T_RP);
            CMD_REF:   need = GAP_W'(T_RFC);
            CMD_LOAD:  need = GAP_W'(T_MRD);
            CMD_ACT:   need = GAP_W'(T_RCD);
            CMD_WRITE: need = GAP_W'(T_WR + T_RP);
            CMD_READ:  need = GAP_W'(T_CL + T_RP);
            default:   need = '0;
        endcase
    end

    // R1
    cke_low_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> cmd == CMD_NOP);

    // R4
    mode_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_op |-> mode_seen);

    // R6
    col_autopre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_col |-> (ap_bit && row_open && ba == act_ba));

    // R7
    rcd_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_NOP && last_cmd == CMD_ACT) |-> (is_col && gap >= need));

    // R8
    col_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_NOP && (last_cmd == CMD_READ || last_cmd == CMD_WRITE)) |-> gap >= need);

    // R9
    misc_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_NOP && (last_cmd == CMD_PRE || last_cmd == CMD_REF || last_cmd == CMD_LOAD))
        |-> gap >= need);

    // R12
    oe_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe == (cmd == CMD_WRITE));

    // R13
    rvalid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(cmd, T_CL + 1) == CMD_READ);

    // R14
    accept_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && host_ready) |=> cmd == CMD_ACT);

endmodule

bind sdram_seq_ctrl sdr_seq_chk #(
    .BA_W(BA_W), .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC),
    .T_MRD(T_MRD), .T_WR(T_WR), .T_CL(T_CL)
) u_seq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd        ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}),
    .cke        (sd_cke),
    .ba         (sd_ba),
    .ap_bit     (sd_addr[10]),
    .dq_oe      (sd_dq_oe),
    .rvalid     (host_rvalid),
    .host_valid (host_valid),
    .host_ready (host_ready)
);

// File: tb/sim_sdram_seq_ctrl.sv
// Bench: a behavioural memory and protocol model evaluated on every clock.
module sim_sdram_seq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int T_POWERUP  = 20;
    localparam int T_RCD = 2, T_RP = 2, T_RFC = 7, T_CL = 2, T_MRD = 2, T_WR = 2;
    localparam int INIT_REFS  = 2;
    localparam int T_REFI     = 120;
    localparam int REF_PERIOD = T_REFI * 8192;
    localparam int SLACK      = 10;

    localparam logic [3:0] C_LOAD = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                           C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101, C_NOP = 4'b0111;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0;
    logic        host_write = 1'b0;
    logic [24:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic        host_ready;
    logic [15:0] host_rdata;
    logic        host_rvalid;
    logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [12:0] sd_addr;
    logic [1:0]  sd_dqm;
    logic [15:0] sd_dq_out;
    logic        sd_dq_oe;
    logic [15:0] sd_dq_in = '0;

    sdram_seq_ctrl #(
        .T_POWERUP(T_POWERUP), .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC),
        .T_CL(T_CL), .T_MRD(T_MRD), .T_WR(T_WR), .INIT_REFS(INIT_REFS),
        .REF_PERIOD_CYC(REF_PERIOD)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_write(host_write),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid), .sd_cke(sd_cke),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out),
        .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int need_after(input logic [3:0] c);
        case (c)
            C_PRE:   return T_RP;
            C_REF:   return T_RFC;
            C_LOAD:  return T_MRD;
            C_ACT:   return T_RCD;
            C_WR:    return T_WR + T_RP;
            C_RD:    return T_CL + T_RP;
            default: return 0;
        endcase
    endfunction

    // Model state
    int          ncyc = 0;
    int          cke_rise = -1;
    bit          first_seen = 0;
    int          last_cyc = 0;
    logic [3:0]  last_cmd = C_NOP;
    int          init_refs = 0;
    bit          mode_seen = 0;
    int          mode_cyc = 0;
    int          last_ref = -1;
    int          post_refs = 0;
    bit          busy_phase = 0;
    bit          row_open = 0;
    logic [1:0]  open_ba = '0;
    logic [24:0] cur_addr = '0;
    logic [15:0] cur_data = '0;
    int          expect_act = -1;
    logic [24:0] acc_addr[$];
    logic [15:0] acc_data[$];
    int          rv_due[$];
    logic [15:0] rv_dat[$];
    int          dq_due[$];
    logic [15:0] dq_dat[$];
    logic [15:0] mem[int];

    // Per-cycle reference model, sampled away from the active edge.
    always @(negedge clk) begin
        logic [3:0] c;
        c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        ncyc++;
        if (!rst_n) begin
            chk(!sd_cke && c == C_NOP && !sd_dq_oe && !host_rvalid, "R1", "reset outputs",
                {sd_cke, c, sd_dq_oe, host_rvalid}, {1'b0, C_NOP, 2'b00});
        end else begin
            if (sd_cke && cke_rise < 0) cke_rise = ncyc;
            if (!sd_cke) chk(c == C_NOP, "R1", "cke low command", c, C_NOP);
            if (c != C_NOP) begin
                if (!first_seen) begin
                    first_seen = 1;
                    chk(c == C_PRE && sd_addr[10], "R2", "first command", {c, sd_addr}, {C_PRE, 13'h400});
                    chk(ncyc - cke_rise >= T_POWERUP, "R2", "power-up wait", ncyc - cke_rise, T_POWERUP);
                end else begin
                    if (last_cmd == C_ACT)
                        chk(ncyc - last_cyc >= need_after(last_cmd), "R7", "act to column", ncyc - last_cyc, need_after(last_cmd));
                    else if (last_cmd == C_WR || last_cmd == C_RD)
                        chk(ncyc - last_cyc >= need_after(last_cmd), "R8", "column to next", ncyc - last_cyc, need_after(last_cmd));
                    else
                        chk(ncyc - last_cyc >= need_after(last_cmd), "R9", "spacing", ncyc - last_cyc, need_after(last_cmd));
                end
                case (c)
                    C_REF: begin
                        if (!mode_seen) init_refs++;
                        else begin
                            if (last_ref >= 0) begin
                                chk(ncyc - last_ref <= T_REFI + SLACK && ncyc - last_ref >= T_REFI - SLACK,
                                    busy_phase ? "R11" : "R10", "refresh interval", ncyc - last_ref, T_REFI);
                            end
                            last_ref = ncyc;
                            post_refs++;
                        end
                    end
                    C_LOAD: begin
                        chk(init_refs == INIT_REFS, "R3", "init refresh count", init_refs, INIT_REFS);
                        chk(sd_addr == 13'h020 && sd_ba == 2'b00, "R4", "mode word", {sd_ba, sd_addr}, 15'h0020);
                        mode_seen = 1;
                        mode_cyc = ncyc;
                    end
                    C_ACT: begin
                        chk(mode_seen, "R4", "activate before mode load", mode_seen, 1);
                        chk(acc_addr.size() > 0, "R14", "activate without request", acc_addr.size(), 1);
                        if (acc_addr.size() > 0) begin
                            cur_addr = acc_addr.pop_front();
                            cur_data = acc_data.pop_front();
                        end
                        chk(sd_ba == cur_addr[24:23] && sd_addr == cur_addr[22:10], "R5", "bank/row",
                            {sd_ba, sd_addr}, cur_addr[24:10]);
                        row_open = 1;
                        open_ba = sd_ba;
                    end
                    C_WR, C_RD: begin
                        chk(row_open && sd_ba == open_ba && sd_addr[12:10] == 3'b001, "R6", "auto precharge column",
                            {row_open, sd_ba, sd_addr[12:10]}, {1'b1, open_ba, 3'b001});
                        chk(sd_addr[9:0] == cur_addr[9:0] && sd_ba == cur_addr[24:23], "R5", "column",
                            {sd_ba, sd_addr[9:0]}, {cur_addr[24:23], cur_addr[9:0]});
                        row_open = 0;
                        if (c == C_WR) begin
                            chk(sd_dq_oe && sd_dqm == 2'b00 && sd_dq_out == cur_data, "R12", "write data",
                                {sd_dq_oe, sd_dqm, sd_dq_out}, {3'b100, cur_data});
                            mem[int'(cur_addr)] = sd_dq_out;
                        end else begin
                            logic [15:0] v;
                            v = mem.exists(int'(cur_addr)) ? mem[int'(cur_addr)] : (cur_addr[15:0] ^ 16'hA5A5);
                            dq_due.push_back(ncyc + T_CL);
                            dq_dat.push_back(v);
                            rv_due.push_back(ncyc + T_CL + 1);
                            rv_dat.push_back(v);
                        end
                    end
                    default: ;
                endcase
                last_cyc = ncyc;
                last_cmd = c;
            end
            if (ncyc == expect_act)
                chk(c == C_ACT, "R14", "activate after accept", c, C_ACT);
            if (c != C_WR)
                chk(!sd_dq_oe, "R12", "driver off", sd_dq_oe, 0);
            if (rv_due.size() > 0 && rv_due[0] == ncyc) begin
                logic [15:0] e;
                void'(rv_due.pop_front());
                e = rv_dat.pop_front();
                chk(host_rvalid && host_rdata == e, "R13", "read return", {host_rvalid, host_rdata}, {1'b1, e});
            end else begin
                chk(!host_rvalid, "R13", "stray strobe", host_rvalid, 0);
            end
            if (dq_due.size() > 0 && dq_due[0] == ncyc) begin
                void'(dq_due.pop_front());
                sd_dq_in = dq_dat.pop_front();
            end
            if (host_valid && host_ready) begin
                acc_addr.push_back(host_addr);
                acc_data.push_back(host_wdata);
                expect_act = ncyc + 1;
            end
        end
    end

    task automatic host_req(input bit wr, input logic [24:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        host_valid = 1'b1;
        host_write = wr;
        host_addr  = a;
        host_wdata = d;
        forever begin
            @(negedge clk);
            if (host_ready) break;
        end
        @(posedge clk); #1;
        host_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [24:0] lfsr;
        lfsr = 25'h1ACE5;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        wait (mode_seen);
        repeat (4) @(posedge clk);
        // R5 R12 corner addresses
        host_req(1, 25'h0000000, 16'h1234);
        host_req(1, 25'h1FFFFFF, 16'hBEEF);
        host_req(1, {2'd2, 13'd5, 10'd7}, 16'h0F0F);
        host_req(1, {2'd1, 13'd4096, 10'd512}, 16'hC3C3);
        // R13 read back, including a location never written
        host_req(0, 25'h1FFFFFF, 16'h0);
        host_req(0, 25'h0000000, 16'h0);
        host_req(0, {2'd2, 13'd5, 10'd7}, 16'h0);
        host_req(0, {2'd1, 13'd4096, 10'd512}, 16'h0);
        host_req(0, {2'd3, 13'd77, 10'd1}, 16'h0);
        // R11 continuous traffic across many refresh intervals
        busy_phase = 1;
        for (int i = 0; i < 150; i++) begin
            lfsr = {lfsr[23:0], lfsr[24] ^ lfsr[21]};
            host_req(1, lfsr, lfsr[15:0] ^ 16'(i));
            host_req(0, lfsr, 16'h0);
        end
        busy_phase = 0;
        repeat (20) @(posedge clk);
        @(negedge clk); #1;
        chk(rv_due.size() == 0, "R13", "outstanding reads", rv_due.size(), 0);
        chk(post_refs >= (ncyc - mode_cyc) / T_REFI - 1, "R10", "refresh count",
            post_refs, (ncyc - mode_cyc) / T_REFI - 1);
        finish_run();
    end

endmodule